// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a byte-wide, register-programmed SPI host that runs one complete flash command each time software triggers it. Software loads an opcode register, a packed register holding the transmit and receive byte counts, and the transmit payload, which it pushes through a single data port into an eight-slot ring buffer. It then sets a go bit and polls it. While the bit reads 1, the engine drives chip select low and shifts out the opcode, then the payload. It then clocks in the response bytes. The bit clears once chip select has returned high.

The ring buffer is shared by both directions and is never wiped. Each byte clocked after the opcode writes the byte sampled from MISO into the slot it came from. Response bytes fill the slots that follow. To collect the results, software clears the ring pointer and reads back through the same data port. The pointer is visible in a status byte, and a two-bit field in that byte sets the SCK rate as a divider of the system clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: The opcode at offset 0x0 is always the first byte on MOSI and never comes from the ring. Every byte is sent MSB first in SPI mode 0: MOSI changes only on falling SCK edges and MISO is sampled on rising edges.
- R2: Offset 0x1 holds the receive count in bits 7:4 and the transmit count in bits 3:0. A count above 8 acts as 8. The engine never alters this register, so it reads back exactly as written.
- R3: At offset 0x2, writing 1 to bit 0 starts a transaction. Bit 0 reads 1 while the engine is busy and 0 once it has finished. Writing 1 to bit 4 sets the ring pointer to 0.
- R4: Each write or read at offset 0xC accesses the ring slot at the pointer and then advances the pointer by one, wrapping modulo 8. Bits 2:0 of offset 0xD return the pointer.
- R5: For a transmit count W, ring slots 0..W-1 are shifted out in order after the opcode. Each of these slots is then overwritten with the byte captured while it was shifted.
- R6: For a receive count R, R further bytes are clocked with MOSI held at 0x00. The captured bytes land in slots W..W+R-1, modulo 8. This includes the case W = 0, and no response byte is dropped.
- R7: Ring slots outside those written by the transaction keep their contents.
- R8: Bits 5:4 of offset 0xD hold a speed code s. Each SCK half-period lasts s+1 system clocks.
- R9: Chip select falls 3(s+1) clocks before the first rising SCK edge. It rises s+1 clocks after the last falling edge. Exactly 8(1+W+R) rising edges occur while it is low, SCK stays low while it is high, and bit 0 of offset 0x2 never reads 0 while chip select is low.
- R10: While busy, writes to the opcode, count, speed and data port are ignored, and so is the pointer-clear bit. The pointer does not move.
- R11: After reset, chip select is high, SCK is low, and the opcode, count, control and status bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; advances the pointer at the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench runs a command with no transmit bytes. An engine that drops the final response byte, or raises chip select early, shows a short edge count and a wrong last slot. A transaction with both counts above 8 wraps the ring. If the capture slot index were off by one, or the clamp missing, the wrapped slots and the edge count would come out wrong. Register writes issued in the middle of a slow transfer must leave the opcode, count, speed and pointer untouched. A design that gates only some of them shows a changed readback. The bench times chip select and SCK at every speed code, so a wrong divider or missing setup time appears as a time difference.

// File: rtl/spi_eng_pkg.sv
// Package: shared offsets, control bit positions and engine state type.
// Assumes a 4-bit byte offset space; offsets are fixed by the software view.
package spi_eng_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] OFS_OPCODE = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h1;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 4'hD;
    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_CLR_BIT = 4;
    localparam int STAT_SPD_LSB = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_TRAIL, ST_FIN
    } eng_state_t;
endpackage

// File: rtl/spi_eng_ring.sv
// Module: ring storage shared by transmit and receive.
// Two write ports (host, engine) and two combinational read ports.
// Assumes the host and engine never write in the same cycle (host writes
// are blocked while busy); the engine port wins if they ever do.
module spi_eng_ring #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [PTR_W-1:0] host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             eng_we,
    input  logic [PTR_W-1:0] eng_waddr,
    input  logic [7:0]       eng_wdata,
    input  logic [PTR_W-1:0] eng_raddr,
    output logic [7:0]       eng_rdata
);
    logic [7:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Purpose: update one slot from whichever port targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (eng_we && eng_waddr == PTR_W'(g)) begin
                slot_q[g] <= eng_wdata;
            end else if (host_we && host_addr == PTR_W'(g)) begin
                slot_q[g] <= host_wdata;
            end
        end
    end

    assign host_rdata = slot_q[host_addr];
    assign eng_rdata  = slot_q[eng_raddr];

    // R10
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> !host_we);
endmodule

// File: rtl/spi_eng_regs.sv
// Module: byte-wide register file, ring pointer and read multiplexer.
// Assumes single-cycle strobes; when both strobes are high a write wins.
// All host side effects are suppressed while the engine reports busy.
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SPD_W = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              busy,
    input  logic [7:0]        ring_rdata,
    output logic              ring_we,
    output logic [PTR_W-1:0]  ptr,
    output logic [7:0]        opcode,
    output logic [CNT_W-1:0]  tx_len,
    output logic [CNT_W-1:0]  rx_len,
    output logic [SPD_W-1:0]  speed,
    output logic              go
);
    logic [7:0]       opc_q;
    logic [7:0]       cnt_q;
    logic [SPD_W-1:0] spd_q;
    logic [PTR_W-1:0] ptr_q;
    logic             wr_ok;
    logic [7:0]       stat_byte;

    assign wr_ok = wr && !busy;

    // Purpose: capture register writes and move the ring pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_q <= '0;
            cnt_q <= '0;
            spd_q <= '0;
            ptr_q <= '0;
        end else if (!busy) begin
            if (wr) begin
                unique case (addr)
                    OFS_OPCODE: opc_q <= wdata;
                    OFS_COUNT:  cnt_q <= wdata;
                    OFS_STAT:   spd_q <= wdata[STAT_SPD_LSB +: SPD_W];
                    OFS_DATA:   ptr_q <= ptr_q + 1'b1;
                    OFS_CTRL:   if (wdata[CTRL_CLR_BIT]) ptr_q <= '0;
                    default:    ;
                endcase
            end else if (rd && addr == OFS_DATA) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Purpose: clamp a 4-bit count field to the ring depth.
    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [3:0] n);
        return (int'(n) > DEPTH) ? CNT_W'(DEPTH) : CNT_W'(n);
    endfunction

    assign tx_len  = clamp_cnt(cnt_q[3:0]);
    assign rx_len  = clamp_cnt(cnt_q[7:4]);
    assign opcode  = opc_q;
    assign speed   = spd_q;
    assign ptr     = ptr_q;
    assign go      = wr_ok && addr == OFS_CTRL && wdata[CTRL_GO_BIT];
    assign ring_we = wr_ok && addr == OFS_DATA;

    // Purpose: assemble the status byte (pointer low, speed code above).
    always_comb begin
        stat_byte = '0;
        stat_byte[PTR_W-1:0] = ptr_q;
        stat_byte[STAT_SPD_LSB +: SPD_W] = spd_q;
    end

    // Purpose: select read data by offset.
    always_comb begin
        unique case (addr)
            OFS_OPCODE: rdata = opc_q;
            OFS_COUNT:  rdata = cnt_q;
            OFS_CTRL:   rdata = {7'b0, busy};
            OFS_DATA:   rdata = ring_rdata;
            OFS_STAT:   rdata = stat_byte;
            default:    rdata = '0;
        endcase
    end

    // R10
    opc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(opc_q));
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cnt_q));
    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ptr_q) && $stable(spd_q)));
endmodule

// File: rtl/spi_eng_shift.sv
// Module: SPI mode-0 shift sequencer with chip select and SCK divider.
// Byte 0 is the opcode; bytes 1..W come from ring slots 0..W-1; the
// remaining R bytes send 0x00. Every byte after the opcode writes its
// captured value to slot (index-1) mod DEPTH. Each SCK half-period is
// speed+1 clocks; assumes counts are already clamped to DEPTH.
module spi_eng_shift
    import spi_eng_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SPD_W = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(2 * DEPTH + 2),
    localparam int TMR_W = SPD_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       opcode,
    input  logic [CNT_W-1:0] tx_len,
    input  logic [CNT_W-1:0] rx_len,
    input  logic [SPD_W-1:0] speed,
    output logic [PTR_W-1:0] slot_raddr,
    input  logic [7:0]       slot_rdata,
    output logic             slot_we,
    output logic [PTR_W-1:0] slot_waddr,
    output logic [7:0]       slot_wdata,
    output logic             busy,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    eng_state_t       state_q;
    logic [TMR_W-1:0] tmr_q;
    logic [TMR_W-1:0] half_t;
    logic [2:0]       bit_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic [CNT_W-1:0] tx_q;
    logic [CNT_W-1:0] rx_q;
    logic [SPD_W-1:0] spd_q;
    logic [7:0]       tx_sh_q;
    logic [7:0]       rx_sh_q;
    logic             sck_q;
    logic             cs_n_q;
    logic             tmr_done;
    logic             byte_end;

    assign half_t   = TMR_W'(spd_q) + 1'b1;
    assign last_idx = IDX_W'(tx_q) + IDX_W'(rx_q);
    assign tmr_done = (tmr_q == '0);
    assign byte_end = (state_q == ST_HIGH) && tmr_done && (bit_q == 3'd7);

    // Purpose: sequence chip select, SCK phases and the shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            bit_q   <= '0;
            idx_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            spd_q   <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        state_q <= ST_LEAD;
                        cs_n_q  <= 1'b0;
                        tx_sh_q <= opcode;
                        tx_q    <= tx_len;
                        rx_q    <= rx_len;
                        spd_q   <= speed;
                        idx_q   <= '0;
                        bit_q   <= '0;
                        tmr_q   <= TMR_W'((int'(speed) + 1) * 2 - 1);
                    end
                end
                ST_LEAD: begin
                    if (tmr_done) begin
                        state_q <= ST_LOW;
                        tmr_q   <= half_t - 1'b1;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (tmr_done) begin
                        state_q <= ST_HIGH;
                        sck_q   <= 1'b1;
                        rx_sh_q <= {rx_sh_q[6:0], miso};
                        tmr_q   <= half_t - 1'b1;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tmr_done) begin
                        sck_q <= 1'b0;
                        tmr_q <= half_t - 1'b1;
                        if (bit_q == 3'd7) begin
                            if (idx_q == last_idx) begin
                                state_q <= ST_TRAIL;
                            end else begin
                                state_q <= ST_LOW;
                                idx_q   <= idx_q + 1'b1;
                                bit_q   <= '0;
                                tx_sh_q <= (idx_q < IDX_W'(tx_q)) ? slot_rdata : 8'h00;
                            end
                        end else begin
                            state_q <= ST_LOW;
                            bit_q   <= bit_q + 1'b1;
                            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                        end
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (tmr_done) begin
                        state_q <= ST_FIN;
                        cs_n_q  <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_FIN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign slot_raddr = idx_q[PTR_W-1:0];
    assign slot_we    = byte_end && (idx_q != '0);
    assign slot_waddr = PTR_W'(idx_q - 1'b1);
    assign slot_wdata = rx_sh_q;
    assign busy       = (state_q != ST_IDLE);
    assign sck        = sck_q;
    assign cs_n       = cs_n_q;
    assign mosi       = cs_n_q ? 1'b0 : tx_sh_q[7];

    // R9
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sck_q);
    // R9
    done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> cs_n_q);
    // R1
    mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(tx_sh_q));
    // R5
    capture_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_we |-> (idx_q <= last_idx));
endmodule

// File: rtl/spi_cmd_engine.sv
// Module: top of the SPI command engine; joins the register file, the
// shared ring and the shift sequencer. Assumes a host that polls the go
// bit and issues one strobe per byte.
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SPD_W = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             busy;
    logic             go;
    logic             host_we;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       host_rdata;
    logic [7:0]       opcode;
    logic [CNT_W-1:0] tx_len;
    logic [CNT_W-1:0] rx_len;
    logic [SPD_W-1:0] speed;
    logic             eng_we;
    logic [PTR_W-1:0] eng_waddr;
    logic [PTR_W-1:0] eng_raddr;
    logic [7:0]       eng_wdata;
    logic [7:0]       eng_rdata;

    spi_eng_regs #(.DEPTH(DEPTH), .SPD_W(SPD_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy),
        .ring_rdata(host_rdata), .ring_we(host_we), .ptr(ptr),
        .opcode(opcode), .tx_len(tx_len), .rx_len(rx_len),
        .speed(speed), .go(go)
    );

    spi_eng_ring #(.DEPTH(DEPTH)) ring_i (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(ptr), .host_wdata(bus_wdata),
        .host_rdata(host_rdata),
        .eng_we(eng_we), .eng_waddr(eng_waddr), .eng_wdata(eng_wdata),
        .eng_raddr(eng_raddr), .eng_rdata(eng_rdata)
    );

    spi_eng_shift #(.DEPTH(DEPTH), .SPD_W(SPD_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .go(go), .opcode(opcode),
        .tx_len(tx_len), .rx_len(rx_len), .speed(speed),
        .slot_raddr(eng_raddr), .slot_rdata(eng_rdata),
        .slot_we(eng_we), .slot_waddr(eng_waddr), .slot_wdata(eng_wdata),
        .busy(busy), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .miso(spi_miso)
    );

    // R3
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
endmodule

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spi_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // Device model: byte k of a frame is {seed, k[3:0]}.
    logic [3:0] dev_seed = 4'h0;
    int dk = 0, db = 0;
    function automatic logic [7:0] dev_byte(input int k);
        return {dev_seed, 4'(k)};
    endfunction

    logic [7:0] mlog [24];
    logic [7:0] mcur = '0;
    int mbits = 0, mlen = 0, rises = 0;
    time t_csf, t_r1, t_r2, t_lf, t_csr;

    always @(negedge spi_cs_n) begin
        t_csf = $time; dk = 0; db = 0;
        spi_miso = dev_byte(0)[7];
    end
    always @(posedge spi_cs_n) t_csr = $time;
    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (rises == 0) t_r1 = $time;
        if (rises == 1) t_r2 = $time;
        rises++;
        mcur = {mcur[6:0], spi_mosi};
        mbits++;
        if (mbits == 8) begin
            if (mlen < 24) mlog[mlen] = mcur;
            mlen++; mbits = 0;
        end
    end
    always @(negedge spi_sck) if (!spi_cs_n) begin
        t_lf = $time;
        db++;
        if (db == 8) begin db = 0; dk++; end
        spi_miso = dev_byte(dk)[7-db];
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic clear_log();
        mlen = 0; mbits = 0; rises = 0;
    endtask

    task automatic wait_done();
        logic [7:0] d;
        int n = 0;
        do begin
            rd(4'h2, d);
            n++;
        end while (d[0] && n < 5000);
        chk("R3 go bit clears", n < 5000, 1);
        chk("R9 cs high when done", spi_cs_n, 1);
    endtask

    task automatic preload(input logic [7:0] base);
        wr(4'h2, 8'h10);
        for (int i = 0; i < 8; i++) wr(4'hC, base + 8'(i));
        wr(4'h2, 8'h10);
    endtask

    task automatic start_txn(input logic [7:0] op, input logic [7:0] cnt, input logic [3:0] seed);
        dev_seed = seed;
        clear_log();
        wr(4'h0, op);
        wr(4'h1, cnt);
        wr(4'h2, 8'h01);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R11 cs_n", spi_cs_n, 1);
        chk("R11 sck", spi_sck, 0);
        rd(4'h0, d); chk("R11 opcode", d, 0);
        rd(4'h1, d); chk("R11 count", d, 0);
        rd(4'h2, d); chk("R11 ctrl", d, 0);
        rd(4'hD, d); chk("R11 status", d, 0);
    endtask

    task automatic t_read_only();
        logic [7:0] d;
        preload(8'h10);
        start_txn(8'h9F, 8'h30, 4'h5);
        wait_done();
        chk("R9 edge count W0R3", rises, 32);
        chk("R1 opcode first", mlog[0], 8'h9F);
        for (int i = 1; i < 4; i++) chk("R6 mosi zero", mlog[i], 0);
        rd(4'h1, d); chk("R2 count unchanged", d, 8'h30);
        rd(4'hD, d); chk("R4 ptr untouched", d[2:0], 0);
        for (int i = 0; i < 3; i++) begin
            rd(4'hC, d); chk("R6 response W0", d, dev_byte(i + 1));
        end
        for (int i = 3; i < 8; i++) begin
            rd(4'hC, d); chk("R7 slot kept", d, 8'h10 + 8'(i));
        end
        rd(4'hD, d); chk("R4 ptr wrap", d[2:0], 0);
    endtask

    task automatic t_write_read();
        logic [7:0] d;
        preload(8'h20);
        wr(4'hC, 8'hAA); wr(4'hC, 8'hBB); wr(4'hC, 8'hCC);
        rd(4'hD, d); chk("R4 ptr after 3 writes", d[2:0], 3);
        wr(4'h2, 8'h10);
        rd(4'hD, d); chk("R3 ptr clear", d[2:0], 0);
        start_txn(8'h03, 8'h23, 4'h7);
        wait_done();
        chk("R9 edge count W3R2", rises, 48);
        chk("R1 opcode", mlog[0], 8'h03);
        chk("R5 tx0", mlog[1], 8'hAA);
        chk("R5 tx1", mlog[2], 8'hBB);
        chk("R5 tx2", mlog[3], 8'hCC);
        chk("R6 rx mosi", mlog[4] | mlog[5], 0);
        wr(4'h2, 8'h10);
        for (int i = 0; i < 5; i++) begin
            rd(4'hC, d); chk("R5 R6 captured", d, dev_byte(i + 1));
        end
        for (int i = 5; i < 8; i++) begin
            rd(4'hC, d); chk("R7 slot kept", d, 8'h20 + 8'(i));
        end
    endtask

    task automatic t_speed();
        logic [7:0] d;
        for (int s = 0; s < 4; s++) begin
            wr(4'hD, 8'(s << 4));
            rd(4'hD, d); chk("R8 speed readback", d[5:4], s);
            start_txn(8'h05, 8'h10, 4'h3);
            wait_done();
            chk("R8 sck period", int'(t_r2 - t_r1), 16 * (s + 1));
            chk("R9 cs lead", int'(t_r1 - t_csf), 24 * (s + 1));
            chk("R9 cs trail", int'(t_csr - t_lf), 8 * (s + 1));
            chk("R9 edges W0R1", rises, 16);
        end
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        wr(4'hD, 8'h30);
        wr(4'h2, 8'h10);
        wr(4'hC, 8'h3C);
        start_txn(8'h55, 8'h11, 4'h9);
        wr(4'h0, 8'hEE);
        wr(4'h1, 8'h77);
        wr(4'hD, 8'h00);
        wr(4'hC, 8'h99);
        wr(4'h2, 8'h10);
        wait_done();
        rd(4'h0, d); chk("R10 opcode kept", d, 8'h55);
        rd(4'h1, d); chk("R10 count kept", d, 8'h11);
        rd(4'hD, d); chk("R10 speed kept", d[5:4], 3);
        chk("R10 ptr kept", d[2:0], 1);
        chk("R1 opcode busy case", mlog[0], 8'h55);
        chk("R5 tx busy case", mlog[1], 8'h3C);
        wr(4'hD, 8'h00);
    endtask

    task automatic t_clamp();
        logic [7:0] d;
        preload(8'h40);
        start_txn(8'h0B, 8'h9A, 4'hB);
        wait_done();
        chk("R2 clamp edges", rises, 136);
        for (int i = 1; i < 9; i++) chk("R5 tx clamp", mlog[i], 8'h40 + 8'(i - 1));
        rd(4'h1, d); chk("R2 raw count kept", d, 8'h9A);
        wr(4'h2, 8'h10);
        for (int i = 0; i < 8; i++) begin
            rd(4'hC, d); chk("R6 wrapped slot", d, dev_byte(i + 9));
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_only();
        t_write_read();
        t_speed();
        t_busy_ignore();
        t_clamp();
        summary();
    end
endmodule